// File: doc/BRIEF.md
# Program Sequencing Front End with Zero-Overhead Loops

This block is the program-flow front end of a small SIMT processor. It keeps a program counter into a local instruction store of 40-bit words, whose depth is a parameter (512 words being the natural tile size). It resolves the flow-control instructions itself, one clock each: absolute jump, subroutine call and return through a short return-address stack, loop-counter load, loop-and-decrement, and stop. Every other word is handed to the lane sequencer over a valid/ready handshake. After the handoff, the program counter waits for the sequencer's completion strobe before it moves on.

A host writes the instruction store through a dedicated write port at any time, even while a program is running. A start pulse, taken only while the block is idle, begins execution at a supplied address. Loops cost no extra cycles beyond the two single-cycle control words: one sets the counter and one closes the loop body.

Top module: `zol_fetch`

## Requirements
- R1: While reset is asserted and after it releases, running, issueValid, doneFlag and stackErr are all low and pcOut is 0.
- R2: A startPulse taken while running is low makes the block run from startAddr on the next edge, and clears doneFlag and stackErr. A startPulse while running is high is ignored.
- R3: A word whose opcode field (bits [35:30]) is not one of the six control codes is presented unchanged on issueWord with issueValid high until issueReady is seen. pcOut then holds until seqDone, after which it advances by one.
- R4: Opcode 0x23 loads the loop counter from the immediate field (bits [14:0]) in one cycle. Opcode 0x24 takes one cycle: it branches to the address in bits [14:0] when the counter before decrementing exceeds 1, otherwise it falls through, and in both cases it decrements the counter (floor 0). A counter loaded with N runs the body max(N,1) times.
- R5: Opcode 0x20 jumps to the absolute address in bits [14:0] in one cycle.
- R6: Opcode 0x21 pushes the address after itself onto a 4-entry return stack and jumps to bits [14:0]. Opcode 0x22 pops the most recent entry into the program counter. Four nested calls complete without error.
- R7: A call with 4 entries already stacked sets stackErr, and it jumps without pushing. A return with an empty stack sets stackErr and falls through. stackErr stays high until the next accepted start.
- R8: Opcode 0x25 stops the block: running falls, doneFlag rises and stays high, and nothing more is issued until a new start.
- R9: Host writes (hostWrEn, hostWrAddr, hostWrData) are accepted in any state. They do not disturb a word already presented or the program counter. A rewritten word that has not yet been fetched takes effect when it is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host instruction-store write enable |
| hostWrAddr | input | ADDR_W | Host write address |
| hostWrData | input | 40 | Host write data |
| startPulse | input | 1 | Begin execution (used only while idle) |
| startAddr | input | ADDR_W | First address to execute |
| issueValid | output | 1 | Non-control word offered to the sequencer |
| issueWord | output | 40 | Offered instruction word |
| issueReady | input | 1 | Sequencer accepts the offered word |
| seqDone | input | 1 | Sequencer finished the accepted word |
| running | output | 1 | Program in progress |
| doneFlag | output | 1 | Program reached a stop word |
| stackErr | output | 1 | Sticky return-stack overflow/underflow |
| pcOut | output | ADDR_W | Current program counter |

## Verification
The checker assumes the sequencer never raises seqDone unless the block is waiting on a word it has accepted. It also assumes that the host never rewrites the word under the program counter in the very cycle that word is decoded. The bench's sequencer model raises seqDone only a set delay after an accept. Every host rewrite during a run targets a word the counter has not reached while the block is stalled on the sequencer. The start address always lies inside the store, so the start property compares against a value the counter can hold.

// File: rtl/zol_fetch_pkg.sv
package zol_fetch_pkg;
  localparam int WORD_W = 40;
  localparam int IMM_W  = 15;
  localparam int OPC_HI = 35;
  localparam int OPC_LO = 30;

  localparam logic [5:0] OPC_JUMP  = 6'h20;
  localparam logic [5:0] OPC_CALL  = 6'h21;
  localparam logic [5:0] OPC_RET   = 6'h22;
  localparam logic [5:0] OPC_LINIT = 6'h23;
  localparam logic [5:0] OPC_LOOP  = 6'h24;
  localparam logic [5:0] OPC_STOP  = 6'h25;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } fetchState_t;

  typedef struct packed {
    logic loadStart;
    logic jump;
    logic push;
    logic pop;
    logic advance;
    logic loadCnt;
    logic decCnt;
  } flowStrobe_t;
endpackage

// File: rtl/zol_fetch_imem.sv
module zol_fetch_imem #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [zol_fetch_pkg::WORD_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]                 rdAddr,
  output logic [zol_fetch_pkg::WORD_W-1:0]  rdData
);
  logic [zol_fetch_pkg::WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  assign rdData = store[rdAddr];
endmodule

// File: rtl/zol_fetch_dpath.sv
module zol_fetch_dpath
  import zol_fetch_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int STACK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  flowStrobe_t        strb,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [IMM_W-1:0]   imm,
  output logic [ADDR_W-1:0]  pc,
  output logic               cntGtOne,
  output logic               stackFull,
  output logic               stackEmpty
);
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [ADDR_W-1:0] retStack [STACK_DEPTH];
  logic [SP_W-1:0]   sp;
  logic [IMM_W-1:0]  loopCnt;
  logic [ADDR_W-1:0] pcInc;
  logic [IDX_W-1:0]  pushIdx;
  logic [IDX_W-1:0]  topIdx;

  assign pcInc      = pc + ADDR_W'(1);
  assign pushIdx    = IDX_W'(sp);
  assign topIdx     = IDX_W'(sp - SP_W'(1));
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign stackEmpty = (sp == '0);
  assign cntGtOne   = (loopCnt > IMM_W'(1));

  // program counter: start beats jump beats pop beats advance
  always_ff @(posedge clk) begin
    if (!rstN)               pc <= '0;
    else if (strb.loadStart) pc <= startAddr;
    else if (strb.jump)      pc <= imm[ADDR_W-1:0];
    else if (strb.pop)       pc <= retStack[topIdx];
    else if (strb.advance)   pc <= pcInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               sp <= '0;
    else if (strb.loadStart) sp <= '0;
    else if (strb.push)      sp <= sp + SP_W'(1);
    else if (strb.pop)       sp <= sp - SP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (strb.push) retStack[pushIdx] <= pcInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             loopCnt <= '0;
    else if (strb.loadCnt) loopCnt <= imm;
    else if (strb.decCnt && loopCnt != '0) loopCnt <= loopCnt - IMM_W'(1);
  end
endmodule

// File: rtl/zol_fetch_ctrl.sv
module zol_fetch_ctrl
  import zol_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [WORD_W-1:0] curWord,
  input  logic              cntGtOne,
  input  logic              stackFull,
  input  logic              stackEmpty,
  input  logic              issueReady,
  input  logic              seqDone,
  output flowStrobe_t       strb,
  output logic              issueValid,
  output logic [WORD_W-1:0] issueWord,
  output logic              running,
  output logic              doneFlag,
  output logic              stackErr
);
  fetchState_t state, nxtState;
  logic [5:0]  opcode;
  logic        errSet;
  logic        doneSet;
  logic        capture;

  assign opcode = curWord[OPC_HI:OPC_LO];

  always_comb begin
    strb     = '0;
    nxtState = state;
    errSet   = 1'b0;
    doneSet  = 1'b0;
    capture  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.loadStart = 1'b1;
          nxtState       = ST_RUN;
        end
      end
      ST_RUN: begin
        unique case (opcode)
          OPC_JUMP: strb.jump = 1'b1;
          OPC_CALL: begin
            strb.jump = 1'b1;
            if (stackFull) errSet    = 1'b1;
            else           strb.push = 1'b1;
          end
          OPC_RET: begin
            if (stackEmpty) begin
              errSet       = 1'b1;
              strb.advance = 1'b1;
            end else begin
              strb.pop = 1'b1;
            end
          end
          OPC_LINIT: begin
            strb.loadCnt = 1'b1;
            strb.advance = 1'b1;
          end
          OPC_LOOP: begin
            strb.decCnt = 1'b1;
            if (cntGtOne) strb.jump    = 1'b1;
            else          strb.advance = 1'b1;
          end
          OPC_STOP: begin
            doneSet  = 1'b1;
            nxtState = ST_IDLE;
          end
          default: begin
            capture  = 1'b1;
            nxtState = ST_ISSUE;
          end
        endcase
      end
      ST_ISSUE: begin
        if (issueReady) nxtState = ST_WAIT;
      end
      ST_WAIT: begin
        if (seqDone) begin
          strb.advance = 1'b1;
          nxtState     = ST_RUN;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               doneFlag <= 1'b0;
    else if (strb.loadStart) doneFlag <= 1'b0;
    else if (doneSet)        doneFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               stackErr <= 1'b0;
    else if (strb.loadStart) stackErr <= 1'b0;
    else if (errSet)         stackErr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        issueWord <= '0;
    else if (capture) issueWord <= curWord;
  end

  assign issueValid = (state == ST_ISSUE);
  assign running    = (state != ST_IDLE);
endmodule

// File: rtl/zol_fetch.sv
module zol_fetch
  import zol_fetch_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int STACK_DEPTH = 4,
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostWrAddr,
  input  logic [39:0]       hostWrData,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              issueValid,
  output logic [39:0]       issueWord,
  input  logic              issueReady,
  input  logic              seqDone,
  output logic              running,
  output logic              doneFlag,
  output logic              stackErr,
  output logic [ADDR_W-1:0] pcOut
);
  flowStrobe_t       strb;
  logic [WORD_W-1:0] curWord;
  logic              cntGtOne;
  logic              stackFull;
  logic              stackEmpty;

  zol_fetch_imem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_imem (
    .clk    (clk),
    .wrEn   (hostWrEn),
    .wrAddr (hostWrAddr),
    .wrData (hostWrData),
    .rdAddr (pcOut),
    .rdData (curWord)
  );

  zol_fetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .curWord    (curWord),
    .cntGtOne   (cntGtOne),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .issueReady (issueReady),
    .seqDone    (seqDone),
    .strb       (strb),
    .issueValid (issueValid),
    .issueWord  (issueWord),
    .running    (running),
    .doneFlag   (doneFlag),
    .stackErr   (stackErr)
  );

  zol_fetch_dpath #(.ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .startAddr  (startAddr),
    .imm        (curWord[IMM_W-1:0]),
    .pc         (pcOut),
    .cntGtOne   (cntGtOne),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty)
  );
endmodule

// File: rtl/zol_fetch_chk.sv
module zol_fetch_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic [ADDR_W-1:0] startAddr,
  input logic              issueValid,
  input logic [39:0]       issueWord,
  input logic              issueReady,
  input logic              running,
  input logic              doneFlag,
  input logic              stackErr,
  input logic [ADDR_W-1:0] pcOut
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !running && !issueValid && !doneFlag && !stackErr);

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !running |=> running && (pcOut == $past(startAddr)));

  assert_offer_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueReady |=> issueValid && $stable(issueWord) && $stable(pcOut));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    stackErr && !startPulse |=> stackErr);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !running && !issueValid);

  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !issueValid);
endmodule

bind zol_fetch zol_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .startAddr  (startAddr),
  .issueValid (issueValid),
  .issueWord  (issueWord),
  .issueReady (issueReady),
  .running    (running),
  .doneFlag   (doneFlag),
  .stackErr   (stackErr),
  .pcOut      (pcOut)
);

// File: tb/zol_fetch_tb.sv
module zol_fetch_tb;
  localparam int DEPTH  = 32;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rstN;
  logic              hostWrEn;
  logic [ADDR_W-1:0] hostWrAddr;
  logic [39:0]       hostWrData;
  logic              startPulse;
  logic [ADDR_W-1:0] startAddr;
  logic              issueValid;
  logic [39:0]       issueWord;
  logic              issueReady;
  logic              seqDone;
  logic              running;
  logic              doneFlag;
  logic              stackErr;
  logic [ADDR_W-1:0] pcOut;

  int nChecks = 0;
  int nFails  = 0;

  // sequencer model controls
  logic readyEn  = 1'b1;
  logic holdDone = 1'b0;
  int   pendCnt  = 0;
  logic [39:0] logged [64];
  int   nLogged  = 0;

  always #2ns clk = ~clk;

  zol_fetch #(.DEPTH(DEPTH), .STACK_DEPTH(4)) u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .hostWrData(hostWrData), .startPulse(startPulse), .startAddr(startAddr),
    .issueValid(issueValid), .issueWord(issueWord), .issueReady(issueReady),
    .seqDone(seqDone), .running(running), .doneFlag(doneFlag),
    .stackErr(stackErr), .pcOut(pcOut)
  );

  function automatic logic [39:0] opWord(input int tag);
    return {4'h0, 6'h01, 30'(tag)};
  endfunction

  function automatic logic [39:0] ctlWord(input logic [5:0] opc, input int imm);
    return {4'h0, opc, 15'h0, 15'(imm)};
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int addr, input logic [39:0] data);
    hostWrEn   = 1'b1;
    hostWrAddr = ADDR_W'(addr);
    hostWrData = data;
    @(negedge clk);
    hostWrEn   = 1'b0;
  endtask

  task automatic pulseStart(input int addr);
    startPulse = 1'b1;
    startAddr  = ADDR_W'(addr);
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // returns edges from the start edge to the edge that raised doneFlag
  task automatic runProg(input int addr, output int edges);
    nLogged = 0;
    pulseStart(addr);
    edges = 0;
    while (!doneFlag && edges < 3000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  function automatic int atLeastOne(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  // sequencer model: accept when ready, finish pendCnt cycles later
  initial begin
    issueReady = 1'b0;
    seqDone    = 1'b0;
    forever begin
      @(negedge clk);
      seqDone    = 1'b0;
      issueReady = readyEn;
      if (pendCnt > 0) begin
        if (!holdDone) begin
          pendCnt--;
          if (pendCnt == 0) seqDone = 1'b1;
        end
      end else if (issueValid && issueReady) begin
        if (nLogged < 64) logged[nLogged] = issueWord;
        nLogged++;
        pendCnt = 2;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R1..all actual=150000 expected=<150000 cycles");
    $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    int edges;
    int p0;
    rstN = 1'b0; hostWrEn = 1'b0; hostWrAddr = '0; hostWrData = '0;
    startPulse = 1'b0; startAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 running", running == 1'b0, running, 0);
    check("R1 issueValid", issueValid == 1'b0, issueValid, 0);
    check("R1 doneFlag", doneFlag == 1'b0, doneFlag, 0);
    check("R1 stackErr", stackErr == 1'b0, stackErr, 0);
    check("R1 pcOut", pcOut == '0, pcOut, 0);

    // R4 loop with a body, swept over counts
    hostWrite(1, opWord(100));
    hostWrite(2, ctlWord(6'h24, 1));
    hostWrite(3, ctlWord(6'h25, 0));
    for (int n = 0; n <= 6; n++) begin
      hostWrite(0, ctlWord(6'h23, n));
      runProg(0, edges);
      check("R4 body repeats", nLogged == atLeastOne(n), nLogged, atLeastOne(n));
      check("R4 body word", logged[0] == opWord(100), logged[0], opWord(100));
      check("R8 done", doneFlag && !running, doneFlag, 1);
    end

    // R4 empty loop timing: LINIT, LOOP x max(N,1), STOP, each one cycle
    hostWrite(29, ctlWord(6'h24, 29));
    hostWrite(30, ctlWord(6'h25, 0));
    for (int n = 0; n <= 8; n++) begin
      hostWrite(28, ctlWord(6'h23, n));
      runProg(28, edges);
      check("R4 cycles", edges == 2 + atLeastOne(n), edges, 2 + atLeastOne(n));
    end

    // R5 jump skips a word
    hostWrite(24, ctlWord(6'h20, 26));
    hostWrite(25, opWord(7));
    hostWrite(26, opWord(6));
    hostWrite(27, ctlWord(6'h25, 0));
    runProg(24, edges);
    check("R5 jump count", nLogged == 1, nLogged, 1);
    check("R5 jump target", logged[0] == opWord(6), logged[0], opWord(6));

    // R6 four nested calls
    hostWrite(0, ctlWord(6'h21, 10));
    hostWrite(1, opWord(1));
    hostWrite(2, ctlWord(6'h25, 0));
    for (int k = 0; k < 3; k++) begin
      hostWrite(10 + 2 * k, ctlWord(6'h21, 12 + 2 * k));
      hostWrite(11 + 2 * k, ctlWord(6'h22, 0));
    end
    hostWrite(16, opWord(9));
    hostWrite(17, ctlWord(6'h22, 0));
    runProg(0, edges);
    check("R6 nested count", nLogged == 2, nLogged, 2);
    check("R6 innermost", logged[0] == opWord(9), logged[0], opWord(9));
    check("R6 after return", logged[1] == opWord(1), logged[1], opWord(1));
    check("R6 no error", stackErr == 1'b0, stackErr, 0);

    // R7 fifth call overflows and jumps without push
    hostWrite(16, ctlWord(6'h21, 18));
    hostWrite(18, opWord(8));
    hostWrite(19, ctlWord(6'h25, 0));
    runProg(0, edges);
    check("R7 overflow err", stackErr == 1'b1, stackErr, 1);
    check("R7 overflow jump", nLogged == 1 && logged[0] == opWord(8), logged[0], opWord(8));

    // R7 empty return falls through; R2 start clears the error first
    hostWrite(20, ctlWord(6'h22, 0));
    hostWrite(21, opWord(5));
    hostWrite(22, ctlWord(6'h25, 0));
    pulseStart(20);
    check("R2 start clears err", stackErr == 1'b0, stackErr, 0);
    edges = 0;
    nLogged = 0;
    while (!doneFlag && edges < 3000) begin @(negedge clk); edges++; end
    check("R7 underflow err", stackErr == 1'b1, stackErr, 1);
    check("R7 fall through", nLogged == 1 && logged[0] == opWord(5), logged[0], opWord(5));

    // R2 straight-line run clears the sticky error
    hostWrite(3, opWord(30));
    hostWrite(4, opWord(31));
    hostWrite(5, ctlWord(6'h25, 0));
    runProg(3, edges);
    check("R2 err cleared", stackErr == 1'b0, stackErr, 0);
    check("R3 order", nLogged == 2 && logged[0] == opWord(30) && logged[1] == opWord(31),
          logged[1], opWord(31));

    // R3 stall on seqDone, R9 rewrite ahead, R2 start ignored while running
    hostWrite(0, opWord(50));
    hostWrite(1, opWord(51));
    hostWrite(2, ctlWord(6'h25, 0));
    holdDone = 1'b1;
    nLogged = 0;
    pulseStart(0);
    edges = 0;
    while (nLogged == 0 && edges < 100) begin @(negedge clk); edges++; end
    p0 = int'(pcOut);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R3 pc held", int'(pcOut) == p0 && !issueValid, pcOut, p0);
    end
    hostWrite(1, opWord(52));
    check("R9 pc undisturbed", int'(pcOut) == p0, pcOut, p0);
    pulseStart(20);
    check("R2 start ignored", int'(pcOut) == p0 && running, pcOut, p0);
    holdDone = 1'b0;
    edges = 0;
    while (!doneFlag && edges < 200) begin @(negedge clk); edges++; end
    check("R9 rewritten word", nLogged == 2 && logged[1] == opWord(52), logged[1], opWord(52));
    check("R2 no stray error", stackErr == 1'b0, stackErr, 0);

    // R3 offer held while not ready; R9 write elsewhere leaves offer intact
    hostWrite(3, opWord(60));
    hostWrite(4, ctlWord(6'h25, 0));
    readyEn = 1'b0;
    nLogged = 0;
    pulseStart(3);
    edges = 0;
    while (!issueValid && edges < 100) begin @(negedge clk); edges++; end
    for (int c = 0; c < 3; c++) begin
      if (c == 1) hostWrite(10, opWord(77));
      else @(negedge clk);
      check("R3 offer held", issueValid && issueWord == opWord(60) && pcOut == ADDR_W'(3),
            issueWord, opWord(60));
    end
    readyEn = 1'b1;
    edges = 0;
    while (!doneFlag && edges < 200) begin @(negedge clk); edges++; end
    check("R3 offered once", nLogged == 1 && logged[0] == opWord(60), nLogged, 1);
    check("R8 stays done", doneFlag && !running && !issueValid, doneFlag, 1);
    repeat (4) @(negedge clk);
    check("R8 no issue after stop", nLogged == 1 && doneFlag, nLogged, 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule